// File: doc/BRIEF.md
# Prescaled Event Counter with Coherent Byte Reads

This block is a 16-bit up-counter that sits behind an 8-bit register bus. Its count input comes from one of three tick sources: every bus clock cycle, a fixed-frequency tick enable, or an external tick enable. The selected ticks pass through a power-of-two prescaler before they reach the counter. All logic runs on the bus clock. The two tick enables are registered once on that clock before use.

Software reads the count one byte at a time. The first byte read in a pair returns the live byte and, in the same cycle, freezes a copy of the whole 16-bit count. The second byte of the pair is then served from that frozen copy, so the two bytes always belong to the same instant, whichever byte is read first. A write to either count byte zeroes the counter and the prescaler. A write to the control register, or a write to either count byte, releases the frozen copy.

Top module: `bcnt_top`

## Requirements
- R1: After reset the count is 0x0000, the control register reads 0x00 (clock off, divide by 1), and the read latch is idle.
- R2: Address 0 is the control register, with the prescale code in bits [2:0] and the source select in bits [4:3]. Bits [7:5] read as zero. Address 1 is the count high byte and address 2 is the count low byte. Address 3 reads 0x00, and writes to it have no effect. When the read strobe is low, rdata is 0x00.
- R3: Source select 00 stops the counter. 01 advances it on every bus cycle. 10 uses fix_tick and 11 uses ext_tick. Each tick input is registered once before use, and the tick input that is not selected is ignored.
- R4: With prescale code p, the counter advances once per 2^p selected ticks. With select 01, the count N bus cycles after a clear is floor(N / 2^p).
- R5: A write to address 1 or 2 clears both the counter and the prescaler to zero, whatever the written data.
- R6: A count-byte read while the latch is idle returns the live byte and captures all 16 bits. The opposite byte, read later, returns the captured value. This holds for both high-first and low-first order, and the latch then goes back to idle.
- R7: Re-reading the byte that triggered a capture, before the opposite byte is read, returns the captured byte and does not capture again.
- R8: A write to the control register or to either count byte returns the latch to idle, so the next count read returns live data.
- R9: A control write takes effect from the next clock edge; the edge of the write itself still uses the old settings. The counter wraps from 0xFFFF to 0x0000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 2 | Register byte address |
| wr_en | input | 1 | Write strobe, one cycle per access |
| rd_en | input | 1 | Read strobe, one cycle per access |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid while rd_en is high |
| fix_tick | input | 1 | Fixed-frequency tick enable |
| ext_tick | input | 1 | External tick enable |

## Verification
The bench covers both read orders, with the count carried across a byte boundary between the two reads. A design that refreshed the holding copy on the second read, or on a repeated read of the same byte, would return a torn value such as a stale high byte paired with a new low byte. It writes the control register and then clears the counter between a captured read and its partner read. A latch that ignored these writes would return stale held data instead of the live count. Other directed cases cover each prescale extreme, a tick on the input that is not selected, and the 0xFFFF wrap. These catch an off-by-one prescaler mask, crossed source decoding, or a counter that saturates instead of wrapping.

// File: rtl/bcnt_pkg.sv
package bcnt_pkg;
  typedef enum logic [1:0] {
    LAT_IDLE = 2'd0,
    LAT_HI   = 2'd1,
    LAT_LO   = 2'd2
  } lat_st_e;

  typedef enum logic [1:0] {
    SRC_OFF = 2'd0,
    SRC_BUS = 2'd1,
    SRC_FIX = 2'd2,
    SRC_EXT = 2'd3
  } src_e;

  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_HI   = 2'd1;
  localparam logic [1:0] A_LO   = 2'd2;
endpackage

// File: rtl/bcnt_tick_sel.sv
module bcnt_tick_sel #(
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] sel,
  input  logic             fix_tick,
  input  logic             ext_tick,
  output logic             tick
);
  import bcnt_pkg::*;

  localparam int NSRC = 2;

  logic [NSRC-1:0] raw;
  logic [NSRC-1:0] sync_q;

  assign raw = {ext_tick, fix_tick};

  // one register stage per tick input
  for (genvar g = 0; g < NSRC; g++) begin : g_sync
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q[g] <= 1'b0;
      else        sync_q[g] <= raw[g];
    end
  end

  always_comb begin
    unique case (src_e'(sel))
      SRC_OFF: tick = 1'b0;
      SRC_BUS: tick = 1'b1;
      SRC_FIX: tick = sync_q[0];
      SRC_EXT: tick = sync_q[1];
      default: tick = 1'b0;
    endcase
  end
endmodule

// File: rtl/bcnt_prescaler.sv
module bcnt_prescaler #(
  parameter int PS_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            tick,
  input  logic [PS_W-1:0] ps,
  output logic            en
);
  localparam int PRE_W = (1 << PS_W) - 1;

  logic [PRE_W-1:0] pre_q, pre_d, mask;

  always_comb begin
    for (int i = 0; i < PRE_W; i++) mask[i] = (i < int'(ps));
  end

  assign en = tick && ((pre_q & mask) == mask);

  always_comb begin
    if (clr)       pre_d = '0;
    else if (tick) pre_d = pre_q + 1'b1;
    else           pre_d = pre_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end
endmodule

// File: rtl/bcnt_rd_latch.sv
module bcnt_rd_latch #(
  parameter int BUS_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rd_hi,
  input  logic                 rd_lo,
  input  logic                 release_req,
  input  logic [2*BUS_W-1:0]   live,
  output logic [BUS_W-1:0]     hi_byte,
  output logic [BUS_W-1:0]     lo_byte,
  output bcnt_pkg::lat_st_e    st,
  output logic [2*BUS_W-1:0]   hold
);
  import bcnt_pkg::*;

  localparam int CW = 2 * BUS_W;

  lat_st_e       st_q, st_d;
  logic [CW-1:0] hold_q, hold_d;

  always_comb begin
    st_d   = st_q;
    hold_d = hold_q;
    if (release_req) begin
      st_d = LAT_IDLE;
    end else if (rd_hi) begin
      unique case (st_q)
        LAT_IDLE: begin hold_d = live; st_d = LAT_HI; end
        LAT_LO:   st_d = LAT_IDLE;
        default:  st_d = st_q;
      endcase
    end else if (rd_lo) begin
      unique case (st_q)
        LAT_IDLE: begin hold_d = live; st_d = LAT_LO; end
        LAT_HI:   st_d = LAT_IDLE;
        default:  st_d = st_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= LAT_IDLE;
      hold_q <= '0;
    end else begin
      st_q   <= st_d;
      hold_q <= hold_d;
    end
  end

  assign hi_byte = (st_q == LAT_IDLE) ? live[CW-1:BUS_W] : hold_q[CW-1:BUS_W];
  assign lo_byte = (st_q == LAT_IDLE) ? live[BUS_W-1:0]  : hold_q[BUS_W-1:0];
  assign st      = st_q;
  assign hold    = hold_q;
endmodule

// File: rtl/bcnt_top.sv
module bcnt_top #(
  parameter int BUS_W  = 8,
  parameter int ADDR_W = 2,
  parameter int PS_W   = 3,
  parameter int SEL_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [BUS_W-1:0]  wdata,
  output logic [BUS_W-1:0]  rdata,
  input  logic              fix_tick,
  input  logic              ext_tick
);
  import bcnt_pkg::*;

  localparam int CNT_W = 2 * BUS_W;
  localparam int CFG_W = PS_W + SEL_W;

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  // bus decode
  logic ctrl_wr, clr, rd_hi, rd_lo;
  assign ctrl_wr = wr_en && (addr == ADDR_W'(A_CTRL));
  assign clr     = wr_en && ((addr == ADDR_W'(A_HI)) || (addr == ADDR_W'(A_LO)));
  assign rd_hi   = rd_en && (addr == ADDR_W'(A_HI));
  assign rd_lo   = rd_en && (addr == ADDR_W'(A_LO));

  // control register
  logic [PS_W-1:0]  ps_q, ps_d;
  logic [SEL_W-1:0] sel_q, sel_d;

  always_comb begin
    ps_d  = ps_q;
    sel_d = sel_q;
    if (ctrl_wr) begin
      ps_d  = wdata[PS_W-1:0];
      sel_d = wdata[PS_W +: SEL_W];
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      ps_q  <= '0;
      sel_q <= '0;
    end else begin
      ps_q  <= ps_d;
      sel_q <= sel_d;
    end
  end

  // tick source and prescaler
  logic tick, cnt_en;

  bcnt_tick_sel #(.SEL_W(SEL_W)) u_tick_sel (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .sel      (sel_q),
    .fix_tick (fix_tick),
    .ext_tick (ext_tick),
    .tick     (tick)
  );

  bcnt_prescaler #(.PS_W(PS_W)) u_prescaler (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .clr   (clr),
    .tick  (tick),
    .ps    (ps_q),
    .en    (cnt_en)
  );

  // counter
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    if (clr)         cnt_d = '0;
    else if (cnt_en) cnt_d = cnt_q + 1'b1;
    else             cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) cnt_q <= '0;
    else             cnt_q <= cnt_d;
  end

  // coherent read latch
  logic [BUS_W-1:0] lat_hi, lat_lo;
  lat_st_e          lat_st;
  logic [CNT_W-1:0] lat_hold;

  bcnt_rd_latch #(.BUS_W(BUS_W)) u_rd_latch (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .rd_hi       (rd_hi),
    .rd_lo       (rd_lo),
    .release_req (ctrl_wr || clr),
    .live        (cnt_q),
    .hi_byte     (lat_hi),
    .lo_byte     (lat_lo),
    .st          (lat_st),
    .hold        (lat_hold)
  );

  // read mux
  always_comb begin
    rdata = '0;
    if (rd_en) begin
      unique case (addr)
        ADDR_W'(A_CTRL): rdata = BUS_W'({sel_q, ps_q});
        ADDR_W'(A_HI):   rdata = lat_hi;
        ADDR_W'(A_LO):   rdata = lat_lo;
        default:         rdata = '0;
      endcase
    end
  end

  logic [CFG_W-1:0] unused_cfg;
  assign unused_cfg = {sel_q, ps_q};
endmodule

// File: rtl/bcnt_chk.sv
module bcnt_chk #(
  parameter int BUS_W  = 8,
  parameter int ADDR_W = 2,
  parameter int SEL_W  = 2
) (
  input logic                clk,
  input logic                rst_n,
  input logic [ADDR_W-1:0]   addr,
  input logic                wr_en,
  input logic                rd_en,
  input logic [BUS_W-1:0]    rdata,
  input logic [SEL_W-1:0]    sel_q,
  input logic [2*BUS_W-1:0]  cnt_q,
  input bcnt_pkg::lat_st_e   lat_st,
  input logic [2*BUS_W-1:0]  lat_hold
);
  import bcnt_pkg::*;

  localparam int CW = 2 * BUS_W;

  logic clr_w, ctrl_w, rdhi_w;
  assign clr_w  = wr_en && ((addr == ADDR_W'(A_HI)) || (addr == ADDR_W'(A_LO)));
  assign ctrl_w = wr_en && (addr == ADDR_W'(A_CTRL));
  assign rdhi_w = rd_en && (addr == ADDR_W'(A_HI));

  // R5
  clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_w |=> (cnt_q == '0));

  // R9
  step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_w |=> ((cnt_q == $past(cnt_q)) || (cnt_q == CW'($past(cnt_q) + 1'b1))));

  // R3
  off_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((sel_q == '0) && !clr_w) |=> $stable(cnt_q));

  // R6
  capture_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rdhi_w && !wr_en && (lat_st == LAT_IDLE)) |=> ((lat_st == LAT_HI) && (lat_hold == $past(cnt_q))));

  // R7
  held_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lat_st != LAT_IDLE) |=> $stable(lat_hold));

  // R8
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_w || clr_w) |=> (lat_st == LAT_IDLE));

  // R2
  unmapped_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_en || (addr == ADDR_W'(3))) |-> (rdata == '0));
endmodule

bind bcnt_top bcnt_chk #(.BUS_W(BUS_W), .ADDR_W(ADDR_W), .SEL_W(SEL_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .addr     (addr),
  .wr_en    (wr_en),
  .rd_en    (rd_en),
  .rdata    (rdata),
  .sel_q    (sel_q),
  .cnt_q    (cnt_q),
  .lat_st   (lat_st),
  .lat_hold (lat_hold)
);

// File: tb/bcnt_top_bench.sv
`timescale 1ns/1ps
module bcnt_top_bench;
  logic       clk;
  logic       rst_n;
  logic [1:0] addr;
  logic       wr_en, rd_en;
  logic [7:0] wdata, rdata;
  logic       fix_tick, ext_tick;

  int n_chk  = 0;
  int n_fail = 0;
  int edges  = 0;
  bit done   = 0;

  localparam logic [1:0] AC = 2'd0, AH = 2'd1, AL = 2'd2, AX = 2'd3;

  bcnt_top u_bcnt_top (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .fix_tick(fix_tick), .ext_tick(ext_tick)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  typedef struct packed {
    logic [2:0]  ps;
    logic [15:0] k;
    logic [15:0] exp;
  } vec_t;

  localparam vec_t VECS [7] = '{
    '{3'd0, 16'd10,   16'd10},
    '{3'd1, 16'd10,   16'd5},
    '{3'd2, 16'd13,   16'd3},
    '{3'd3, 16'd300,  16'd37},
    '{3'd7, 16'd1000, 16'd7},
    '{3'd4, 16'd0,    16'd0},
    '{3'd0, 16'd700,  16'd700}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
    edges++;
    if (a == AH || a == AL) edges = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    addr = a; rd_en = 1'b1;
    #1 d = rdata;
    @(posedge clk); @(negedge clk);
    rd_en = 1'b0;
    edges++;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); @(negedge clk);
      edges++;
    end
  endtask

  task automatic pulse(input bit ext, input int n);
    for (int i = 0; i < n; i++) begin
      if (ext) ext_tick = 1'b1; else fix_tick = 1'b1;
      idle(1);
      ext_tick = 1'b0; fix_tick = 1'b0;
      idle(1);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    logic [7:0] d;
    rst_n = 1'b0; addr = '0; wr_en = 0; rd_en = 0; wdata = '0;
    fix_tick = 0; ext_tick = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(3);

    // R1 reset state
    rd(AC, d); chk("R1 ctrl", d, 8'h00);
    rd(AH, d); chk("R1 count hi", d, 8'h00);
    rd(AL, d); chk("R1 count lo", d, 8'h00);
    idle(5);
    rd(AL, d); chk("R1 clock off after reset", d, 8'h00);
    rd(AH, d);

    // R4 table of prescale vectors
    foreach (VECS[i]) begin
      wr(AC, {3'b000, 2'b01, VECS[i].ps});
      wr(AH, 8'hA5);
      idle(int'(VECS[i].k));
      rd(AH, d); chk("R4 hi", d, VECS[i].exp[15:8]);
      rd(AL, d); chk("R4 lo", d, VECS[i].exp[7:0]);
    end

    // R2 control read-back, upper bits zero, unmapped address
    wr(AC, 8'hFF);
    rd(AC, d); chk("R2 ctrl upper bits", d, 8'h1F);
    wr(AC, 8'h08);
    wr(AX, 8'hFF);
    rd(AC, d); chk("R2 addr3 write ignored", d, 8'h08);
    rd(AX, d); chk("R2 addr3 reads zero", d, 8'h00);

    // R9 + R3: control write takes effect next edge, select 00 holds
    wr(AL, 8'h00);
    idle(20);
    wr(AC, 8'h00);
    idle(10);
    rd(AL, d); chk("R9 old setting on write edge / R3 hold", d, 8'd21);
    rd(AH, d); chk("R3 hold hi", d, 8'h00);

    // R7 same byte re-read keeps held value
    wr(AC, 8'h08);
    wr(AH, 8'h00);
    idle(250);
    rd(AH, d); chk("R7 first hi", d, 8'h00);
    idle(20);
    rd(AH, d); chk("R7 re-read hi held", d, 8'h00);
    rd(AL, d); chk("R7 partner lo", d, 8'hFA);
    rd(AH, d); chk("R6 fresh hi live", d, 8'h01);
    rd(AL, d); chk("R6 hi-first lo held", d, 8'h11);

    // R6 low-first order
    wr(AL, 8'h3C);
    idle(5);
    rd(AL, d); chk("R6 lo-first lo", d, 8'd5);
    idle(300);
    rd(AH, d); chk("R6 lo-first hi held", d, 8'h00);

    // R8 control write releases latch
    wr(AH, 8'h00);
    idle(8);
    rd(AH, d);
    wr(AC, 8'h08);
    rd(AL, d); chk("R8 ctrl write release", d, 8'd10);
    rd(AH, d);
    // R8 count write releases latch
    rd(AH, d);
    wr(AL, 8'h00);
    idle(3);
    rd(AL, d); chk("R8 count write release", d, 8'd3);
    rd(AH, d);

    // R5 clear with arbitrary data
    idle(40);
    wr(AL, 8'hFF);
    rd(AL, d); chk("R5 clear lo", d, 8'h00);
    rd(AH, d); chk("R5 clear hi", d, 8'h00);

    // R3 fixed tick selected, ext ignored
    wr(AC, 8'h10);
    wr(AH, 8'h00);
    pulse(1'b0, 5);
    pulse(1'b1, 3);
    idle(3);
    rd(AL, d); chk("R3 fixed source", d, 8'd5);
    rd(AH, d);

    // R3/R4 ext tick with divide by 2, fix ignored
    wr(AC, 8'h19);
    wr(AH, 8'h00);
    pulse(1'b1, 6);
    pulse(1'b0, 4);
    idle(3);
    rd(AL, d); chk("R4 ext div2", d, 8'd3);
    rd(AH, d);
    wr(AX, 8'hFF);
    rd(AC, d); chk("R2 ctrl after addr3 write", d, 8'h19);
    rd(AL, d); chk("R2 count after addr3 write", d, 8'd3);
    rd(AH, d);

    // R9 wrap
    wr(AC, 8'h08);
    wr(AH, 8'h00);
    idle(65535);
    rd(AH, d); chk("R9 hi at max", d, 8'hFF);
    rd(AL, d); chk("R9 lo at max", d, 8'hFF);
    rd(AL, d); chk("R9 wrapped lo", d, 8'h01);
    rd(AH, d); chk("R9 wrapped hi", d, 8'h00);

    done = 1;
    finish_run();
  end
endmodule